// File: doc/BRIEF.md
# Stack-Top Data Cache with Automatic Spill and Fill

This block keeps the topmost words of a downward-growing procedure stack in a small on-chip circular buffer. It tracks a stack pointer and a count of resident words. A word is resident when its word offset above the stack pointer is less than that count. Ordinary byte-addressed loads and stores that fall inside this window are served locally. Every other address is passed to a word-wide backing-store port.

Two commands manage the window. An allocate command opens a frame of N words below the stack pointer. When the buffer lacks room, the block first writes the deepest resident words back to memory. A release command first frees P words by raising the stack pointer, then makes sure at least K words above the new pointer are resident, reading missing words back in ascending address order. While a spill, fill or forwarded access runs, the block raises `busy` and accepts no new request or command.

Top module: `stack_cache`

## Requirements
- R1: After reset, `resident_count` is 0, `busy` is 0, no memory request is raised, and `stack_ptr` equals `sp_init` with its two low bits cleared.
- R2: An allocate command (`cmd_op`=1, N=`cmd_words`) that fits (count+N <= 32) lowers `stack_ptr` by 4*N and raises the count by N in the next cycle, with no memory traffic.
- R3: An allocate command that does not fit first writes count+N-32 words back to memory, one at a time, starting from address `stack_ptr`+4*(count-1) and descending, each with its cached data and all four byte enables. It then applies the frame, leaving the count at 32.
- R4: `cmd_words` and `cmd_keep` values above 32 are treated as 32, and the count never exceeds 32.
- R5: A release command (`cmd_op`=2, P=`cmd_words`, K=`cmd_keep`) raises `stack_ptr` by 4*P and lowers the count by P, stopping at zero. When the result is already at least K, no memory traffic follows.
- R6: When the count after release is below K, the block reads words at `stack_ptr`+4*count in ascending order, storing each returned word, until the count equals K.
- R7: A load whose word address lies inside the resident window returns the cached word with `cpu_rvalid` one cycle after acceptance, and causes no memory traffic.
- R8: A store that hits writes only the bytes whose `cpu_be` bit is set (bit b covers data bits 8b+7:8b, little-endian). The other bytes of the word keep their values, and no memory traffic occurs.
- R9: An access outside the window, including below the stack pointer, is issued once on the memory port with the same address, write flag, byte enables and data. A forwarded load returns the memory response on `cpu_rdata` with `cpu_rvalid`.
- R10: `busy` is high from the cycle after a command or access that needs memory until its last transaction completes. A memory request is only ever raised while `busy` is high.
- R11: A memory request held without `mem_req_ready` keeps its address, write flag and data unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sp_init | input | 32 | Stack pointer value loaded at reset |
| cmd_op | input | 2 | 0 none, 1 allocate frame, 2 release and keep |
| cmd_words | input | 6 | Frame size N, or words P to release |
| cmd_keep | input | 6 | Words K that must be resident after release |
| cpu_valid | input | 1 | Load/store request |
| cpu_we | input | 1 | 1 store, 0 load |
| cpu_addr | input | 32 | Byte address |
| cpu_be | input | 4 | Byte enables for stores |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data |
| cpu_rvalid | output | 1 | Load data valid |
| busy | output | 1 | Sequence in progress; requests ignored |
| stack_ptr | output | 32 | Current stack pointer |
| resident_count | output | 6 | Number of resident words |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | Memory write |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_be | output | 4 | Memory byte enables |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_rdata | input | 32 | Read response data |

## Verification
The checks assume that commands and accesses arrive only while `busy` is low. They also assume that a read response comes only for an accepted read, and never in the same cycle as the handshake. The bench waits on `busy` before every request. Its memory model answers each read exactly one cycle after the handshake and withholds ready in a fixed pattern, so held requests occur. No forwarded access targets a resident word, so the bench's reference copy of the stack always matches what the processor should observe.

// File: rtl/sc_pkg.sv
package sc_pkg;
    typedef enum logic [1:0] {
        SC_NOP     = 2'd0,
        SC_ENTER   = 2'd1,
        SC_CLEANUP = 2'd2
    } sc_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SPILL,
        ST_FILL,
        ST_FILL_WAIT,
        ST_FWD,
        ST_FWD_WAIT
    } sc_state_e;
endpackage

// File: rtl/sc_window.sv
module sc_window #(
    parameter int AW    = 32,
    parameter int IDXW  = 5,
    parameter int CNTW  = 6
) (
    input  logic [AW-1:0]   sp,
    input  logic [CNTW-1:0] cnt,
    input  logic [AW-1:0]   addr,
    output logic            hit,
    output logic [IDXW-1:0] idx
);
    logic [AW-3:0] word_ofs;

    always_comb begin
        word_ofs = addr[AW-1:2] - sp[AW-1:2];
        hit      = (word_ofs < (AW-2)'(cnt));
        idx      = addr[IDXW+1:2];
    end
endmodule

// File: rtl/sc_entry_store.sv
module sc_entry_store #(
    parameter int DEPTH = 32,
    parameter int IDXW  = 5,
    parameter int WW    = 32
) (
    input  logic            clk,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [WW/8-1:0] wr_be,
    input  logic [WW-1:0]   wr_data,
    input  logic [IDXW-1:0] rd_idx,
    output logic [WW-1:0]   rd_data
);
    localparam int LANES = WW / 8;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wr_en && wr_be[b]) begin
                lane_mem[wr_idx] <= wr_data[8*b +: 8];
            end
        end

        assign rd_data[8*b +: 8] = lane_mem[rd_idx];
    end
endmodule

// File: rtl/stack_cache.sv
module stack_cache
    import sc_pkg::*;
#(
    parameter int AW    = 32,
    parameter int WW    = 32,
    parameter int DEPTH = 32,
    parameter int CMDW  = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   sp_init,
    input  logic [1:0]      cmd_op,
    input  logic [CMDW-1:0] cmd_words,
    input  logic [CMDW-1:0] cmd_keep,
    input  logic            cpu_valid,
    input  logic            cpu_we,
    input  logic [AW-1:0]   cpu_addr,
    input  logic [WW/8-1:0] cpu_be,
    input  logic [WW-1:0]   cpu_wdata,
    output logic [WW-1:0]   cpu_rdata,
    output logic            cpu_rvalid,
    output logic            busy,
    output logic [AW-1:0]   stack_ptr,
    output logic [CMDW-1:0] resident_count,
    output logic            mem_req_valid,
    input  logic            mem_req_ready,
    output logic            mem_req_we,
    output logic [AW-1:0]   mem_req_addr,
    output logic [WW/8-1:0] mem_req_be,
    output logic [WW-1:0]   mem_req_wdata,
    input  logic            mem_rsp_valid,
    input  logic [WW-1:0]   mem_rsp_rdata
);
    localparam int IDXW  = $clog2(DEPTH);
    localparam int CNTW  = IDXW + 1;
    localparam int LANES = WW / 8;

    typedef struct packed {
        sc_state_e       fsm;
        logic [AW-1:0]   sp;
        logic [CNTW-1:0] cnt;
        logic [CNTW-1:0] pend;
        logic            rvalid;
        logic [WW-1:0]   rdata;
        logic [AW-1:0]   fwd_addr;
        logic            fwd_we;
        logic [LANES-1:0] fwd_be;
        logic [WW-1:0]   fwd_data;
    } sc_regs_t;

    sc_regs_t r_q, r_d;

    function automatic logic [CNTW-1:0] clamp_words(input logic [CMDW-1:0] v);
        return (v > CMDW'(DEPTH)) ? CNTW'(DEPTH) : CNTW'(v);
    endfunction

    function automatic logic [AW-1:0] words_to_bytes(input logic [CNTW-1:0] w);
        return AW'(w) << 2;
    endfunction

    logic            cpu_hit;
    logic [IDXW-1:0] cpu_idx;
    logic [AW-1:0]   spill_addr;
    logic [AW-1:0]   fill_addr;
    logic [IDXW-1:0] rd_idx;
    logic [WW-1:0]   rd_word;
    logic            st_wr_en;
    logic [IDXW-1:0] st_wr_idx;
    logic [LANES-1:0] st_wr_be;
    logic [WW-1:0]   st_wr_data;

    sc_window #(.AW(AW), .IDXW(IDXW), .CNTW(CNTW)) window_i (
        .sp   (r_q.sp),
        .cnt  (r_q.cnt),
        .addr (cpu_addr),
        .hit  (cpu_hit),
        .idx  (cpu_idx)
    );

    sc_entry_store #(.DEPTH(DEPTH), .IDXW(IDXW), .WW(WW)) store_i (
        .clk     (clk),
        .wr_en   (st_wr_en),
        .wr_idx  (st_wr_idx),
        .wr_be   (st_wr_be),
        .wr_data (st_wr_data),
        .rd_idx  (rd_idx),
        .rd_data (rd_word)
    );

    always_comb begin
        spill_addr = r_q.sp + words_to_bytes(r_q.cnt - CNTW'(1));
        fill_addr  = r_q.sp + words_to_bytes(r_q.cnt);
        rd_idx     = (r_q.fsm == ST_SPILL) ? spill_addr[IDXW+1:2] : cpu_idx;
    end

    always_comb begin
        logic [CNTW-1:0] n_w;
        logic [CNTW-1:0] k_w;
        logic [CNTW-1:0] left;

        r_d        = r_q;
        r_d.rvalid = 1'b0;
        n_w        = clamp_words(cmd_words);
        k_w        = clamp_words(cmd_keep);
        left       = '0;

        st_wr_en   = 1'b0;
        st_wr_idx  = cpu_idx;
        st_wr_be   = cpu_be;
        st_wr_data = cpu_wdata;

        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = r_q.fwd_addr;
        mem_req_be    = '1;
        mem_req_wdata = rd_word;

        unique case (r_q.fsm)
            ST_IDLE: begin
                if (sc_cmd_e'(cmd_op) == SC_ENTER) begin
                    if (({1'b0, r_q.cnt} + {1'b0, n_w}) > (CNTW+1)'(DEPTH)) begin
                        r_d.fsm  = ST_SPILL;
                        r_d.pend = n_w;
                    end else begin
                        r_d.sp  = r_q.sp - words_to_bytes(n_w);
                        r_d.cnt = r_q.cnt + n_w;
                    end
                end else if (sc_cmd_e'(cmd_op) == SC_CLEANUP) begin
                    r_d.sp = r_q.sp + words_to_bytes(n_w);
                    left   = (r_q.cnt > n_w) ? (r_q.cnt - n_w) : '0;
                    r_d.cnt = left;
                    if (left < k_w) begin
                        r_d.fsm  = ST_FILL;
                        r_d.pend = k_w;
                    end
                end else if (cpu_valid) begin
                    if (cpu_hit) begin
                        if (cpu_we) begin
                            st_wr_en = 1'b1;
                        end else begin
                            r_d.rvalid = 1'b1;
                            r_d.rdata  = rd_word;
                        end
                    end else begin
                        r_d.fsm      = ST_FWD;
                        r_d.fwd_addr = cpu_addr;
                        r_d.fwd_we   = cpu_we;
                        r_d.fwd_be   = cpu_be;
                        r_d.fwd_data = cpu_wdata;
                    end
                end
            end
            ST_SPILL: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_addr  = spill_addr;
                mem_req_wdata = rd_word;
                if (mem_req_ready) begin
                    left = r_q.cnt - CNTW'(1);
                    if (({1'b0, left} + {1'b0, r_q.pend}) <= (CNTW+1)'(DEPTH)) begin
                        r_d.sp  = r_q.sp - words_to_bytes(r_q.pend);
                        r_d.cnt = left + r_q.pend;
                        r_d.fsm = ST_IDLE;
                    end else begin
                        r_d.cnt = left;
                    end
                end
            end
            ST_FILL: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = fill_addr;
                if (mem_req_ready) begin
                    r_d.fsm = ST_FILL_WAIT;
                end
            end
            ST_FILL_WAIT: begin
                if (mem_rsp_valid) begin
                    st_wr_en   = 1'b1;
                    st_wr_idx  = fill_addr[IDXW+1:2];
                    st_wr_be   = '1;
                    st_wr_data = mem_rsp_rdata;
                    r_d.cnt    = r_q.cnt + CNTW'(1);
                    r_d.fsm    = ((r_q.cnt + CNTW'(1)) >= r_q.pend) ? ST_IDLE : ST_FILL;
                end
            end
            ST_FWD: begin
                mem_req_valid = 1'b1;
                mem_req_we    = r_q.fwd_we;
                mem_req_addr  = r_q.fwd_addr;
                mem_req_be    = r_q.fwd_be;
                mem_req_wdata = r_q.fwd_data;
                if (mem_req_ready) begin
                    r_d.fsm = r_q.fwd_we ? ST_IDLE : ST_FWD_WAIT;
                end
            end
            ST_FWD_WAIT: begin
                if (mem_rsp_valid) begin
                    r_d.rvalid = 1'b1;
                    r_d.rdata  = mem_rsp_rdata;
                    r_d.fsm    = ST_IDLE;
                end
            end
            default: r_d.fsm = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q          <= '0;
            r_q.fsm      <= ST_IDLE;
            r_q.sp       <= {sp_init[AW-1:2], 2'b00};
        end else begin
            r_q <= r_d;
        end
    end

    assign cpu_rdata      = r_q.rdata;
    assign cpu_rvalid     = r_q.rvalid;
    assign busy           = (r_q.fsm != ST_IDLE);
    assign stack_ptr      = r_q.sp;
    assign resident_count = CMDW'(r_q.cnt);
endmodule

// File: rtl/stack_cache_chk.sv
module stack_cache_chk #(
    parameter int AW    = 32,
    parameter int WW    = 32,
    parameter int DEPTH = 32,
    parameter int CMDW  = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      cmd_op,
    input logic            busy,
    input logic [AW-1:0]   stack_ptr,
    input logic [CMDW-1:0] resident_count,
    input logic            mem_req_valid,
    input logic            mem_req_ready,
    input logic            mem_req_we,
    input logic [AW-1:0]   mem_req_addr,
    input logic [WW-1:0]   mem_req_wdata
);
    // R10
    req_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> busy);

    // R11
    req_held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
            (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)
             && $stable(mem_req_wdata)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resident_count <= CMDW'(DEPTH));

    // R1
    sp_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stack_ptr[1:0] == 2'b00);

    // R2
    sp_moves_on_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(stack_ptr) && $past(rst_n)) |->
            ($past(cmd_op) != 2'd0 || $past(busy)));
endmodule

bind stack_cache stack_cache_chk #(
    .AW(AW), .WW(WW), .DEPTH(DEPTH), .CMDW(CMDW)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_op         (cmd_op),
    .busy           (busy),
    .stack_ptr      (stack_ptr),
    .resident_count (resident_count),
    .mem_req_valid  (mem_req_valid),
    .mem_req_ready  (mem_req_ready),
    .mem_req_we     (mem_req_we),
    .mem_req_addr   (mem_req_addr),
    .mem_req_wdata  (mem_req_wdata)
);

// File: tb/stack_cache_tb_top.sv
module stack_cache_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] sp_init = 32'h0000_0800;
    logic [1:0]  cmd_op = '0;
    logic [5:0]  cmd_words = '0, cmd_keep = '0;
    logic        cpu_valid = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic [3:0]  cpu_be = '0;
    logic [31:0] cpu_rdata, stack_ptr, mem_req_addr, mem_req_wdata;
    logic        cpu_rvalid, busy, mem_req_valid, mem_req_we;
    logic [5:0]  resident_count;
    logic [3:0]  mem_req_be;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_rdata = '0;

    always #2 clk = ~clk;

    stack_cache dut_i (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    logic [31:0] bmem [1024];
    logic [31:0] refm [1024];
    logic [31:0] wlog_a [64], wlog_d [64], rlog_a [64];
    logic [3:0]  wlog_be [64];
    int nwr = 0, nrd = 0;

    function automatic logic [31:0] seed_word(int i);
        return 32'hC0DE_0000 ^ (i * 32'h0000_9E37);
    endfunction

    function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
        logic [31:0] r = o;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    initial for (int i = 0; i < 1024; i++) begin
        bmem[i] = seed_word(i);
        refm[i] = seed_word(i);
    end

    // backing store model: ready withheld every third cycle, read data one cycle later
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_req_ready <= ((cyc % 3) != 1);
        mem_rsp_valid <= 1'b0;
        if (mem_req_valid && mem_req_ready) begin
            if (mem_req_we) begin
                bmem[mem_req_addr[11:2]] <= merge(bmem[mem_req_addr[11:2]], mem_req_wdata, mem_req_be);
                if (nwr < 64) begin
                    wlog_a[nwr] <= mem_req_addr; wlog_d[nwr] <= mem_req_wdata; wlog_be[nwr] <= mem_req_be;
                end
                nwr <= nwr + 1;
            end else begin
                mem_rsp_valid <= 1'b1;
                mem_rsp_rdata <= bmem[mem_req_addr[11:2]];
                if (nrd < 64) rlog_a[nrd] <= mem_req_addr;
                nrd <= nrd + 1;
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy) @(negedge clk);
    endtask

    task automatic command(logic [1:0] op, logic [5:0] w, logic [5:0] k, bit expect_busy);
        wait_idle();
        cmd_op = op; cmd_words = w; cmd_keep = k;
        @(negedge clk);
        cmd_op = 2'd0;
        if (expect_busy) chk(busy === 1'b1, "R10 busy after cmd", {31'd0, busy}, 32'd1);
        while (busy) @(negedge clk);
    endtask

    task automatic store(logic [31:0] a, logic [31:0] d, logic [3:0] be);
        wait_idle();
        cpu_valid = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_be = be;
        @(negedge clk);
        cpu_valid = 1'b0;
        refm[a[11:2]] = merge(refm[a[11:2]], d, be);
        while (busy) @(negedge clk);
    endtask

    task automatic load(logic [31:0] a, output logic [31:0] d);
        wait_idle();
        cpu_valid = 1'b1; cpu_we = 1'b0; cpu_addr = a; cpu_be = 4'hF;
        @(negedge clk);
        cpu_valid = 1'b0;
        while (!cpu_rvalid) @(negedge clk);
        d = cpu_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        logic [31:0] d, sp0;
        int w0, r0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(resident_count == 0, "R1 count", {26'd0, resident_count}, 0);
        chk(busy == 1'b0 && mem_req_valid == 1'b0, "R1 idle", {30'd0, busy, mem_req_valid}, 0);
        chk(stack_ptr == 32'h800, "R1 sp", stack_ptr, 32'h800);

        // R2 allocate that fits
        w0 = nwr; r0 = nrd;
        command(2'd1, 6'd8, 6'd0, 1'b0);
        chk(stack_ptr == 32'h7E0, "R2 sp", stack_ptr, 32'h7E0);
        chk(resident_count == 8, "R2 count", {26'd0, resident_count}, 8);
        for (int i = 0; i < 8; i++) store(32'h7E0 + 4*i, {16'hAB00 + 16'(i), 16'h7E0 + 16'(4*i)}, 4'hF);
        // R7 hit loads
        for (int i = 0; i < 8; i++) begin
            load(32'h7E0 + 4*i, d);
            chk(d == refm[(32'h7E0 >> 2) + i], "R7 hit load", d, refm[(32'h7E0 >> 2) + i]);
        end
        chk(nwr == w0 && nrd == r0, "R2 R7 no traffic", nwr + nrd, w0 + r0);

        // R8 byte-lane sweep on one word
        for (int m = 1; m < 16; m++) begin
            store(32'h7E4, 32'h1111_1111 * m, 4'(m));
            load(32'h7E4, d);
            chk(d == refm[32'h7E4 >> 2], "R8 lane write", d, refm[32'h7E4 >> 2]);
        end
        chk(nwr == w0 && nrd == r0, "R8 no traffic", nwr + nrd, w0 + r0);

        // R9 misses above and below window
        load(32'h900, d);
        chk(d == seed_word(32'h900 >> 2), "R9 miss load above", d, seed_word(32'h900 >> 2));
        load(32'h7DC, d);
        chk(d == seed_word(32'h7DC >> 2), "R9 miss load below", d, seed_word(32'h7DC >> 2));
        w0 = nwr;
        store(32'h904, 32'hDEAD_BEEF, 4'h3);
        chk(nwr == w0 + 1 && wlog_a[w0] == 32'h904 && wlog_be[w0] == 4'h3, "R9 fwd store",
            wlog_a[w0], 32'h904);
        load(32'h904, d);
        chk(d == refm[32'h904 >> 2], "R9 merged miss", d, refm[32'h904 >> 2]);

        // R3 allocate that spills six deepest words
        w0 = nwr;
        command(2'd1, 6'd30, 6'd0, 1'b1);
        chk(nwr == w0 + 6, "R3 spill count", nwr - w0, 6);
        for (int k = 0; k < 6; k++) begin
            chk(wlog_a[w0+k] == 32'h7FC - 4*k && wlog_d[w0+k] == refm[(32'h7FC - 4*k) >> 2]
                && wlog_be[w0+k] == 4'hF, "R3 spill order/data", wlog_a[w0+k], 32'h7FC - 4*k);
        end
        chk(stack_ptr == 32'h768 && resident_count == 32, "R3 sp/count", stack_ptr, 32'h768);
        for (int i = 0; i < 30; i++) store(32'h768 + 4*i, 32'h5A00_0000 + i, 4'hF);

        // R4 clamped allocate spills all 32
        w0 = nwr;
        command(2'd1, 6'd40, 6'd0, 1'b1);
        chk(nwr == w0 + 32, "R4 clamp spill", nwr - w0, 32);
        chk(wlog_a[w0+31] == 32'h768 && wlog_d[w0+31] == refm[32'h768 >> 2], "R4 last spill",
            wlog_a[w0+31], 32'h768);
        chk(stack_ptr == 32'h6E8 && resident_count == 32, "R4 sp/count", stack_ptr, 32'h6E8);

        // R5 release all, no fill
        w0 = nwr; r0 = nrd;
        command(2'd2, 6'd32, 6'd0, 1'b0);
        chk(stack_ptr == 32'h768 && resident_count == 0, "R5 release", stack_ptr, 32'h768);
        chk(nwr == w0 && nrd == r0, "R5 no traffic", nwr + nrd, w0 + r0);

        // R6 and R4 clamped keep refills 32 ascending
        command(2'd2, 6'd0, 6'd45, 1'b1);
        chk(nrd == r0 + 32 && resident_count == 32, "R6 fill count", nrd - r0, 32);
        for (int k = 0; k < 32; k++)
            chk(rlog_a[r0+k] == 32'h768 + 4*k, "R6 fill order", rlog_a[r0+k], 32'h768 + 4*k);
        r0 = nrd;
        for (int i = 0; i < 32; i++) begin
            load(32'h768 + 4*i, d);
            chk(d == refm[(32'h768 >> 2) + i], "R6 filled data", d, refm[(32'h768 >> 2) + i]);
        end
        chk(nrd == r0, "R7 fills then hits", nrd, r0);

        // R5 partial release keeps enough, then R6 partial refill
        command(2'd2, 6'd4, 6'd10, 1'b0);
        chk(stack_ptr == 32'h778 && resident_count == 28 && nrd == r0, "R5 partial",
            stack_ptr, 32'h778);
        command(2'd2, 6'd20, 6'd30, 1'b1);
        sp0 = 32'h7C8;
        chk(stack_ptr == sp0 && resident_count == 30 && nrd == r0 + 22, "R6 partial refill",
            nrd - r0, 22);
        chk(rlog_a[r0] == sp0 + 32 && rlog_a[r0+21] == sp0 + 4*29, "R6 refill range",
            rlog_a[r0+21], sp0 + 4*29);
        for (int i = 0; i < 30; i += 3) begin
            load(sp0 + 4*i, d);
            chk(d == refm[(sp0 >> 2) + i], "R6 R7 window data", d, refm[(sp0 >> 2) + i]);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule